// File: doc/BRIEF.md
# Sequential Byte-Sliced Signed/Unsigned Multiplier

This block forms the 32-bit product of two 16-bit operands using a single 8x8 unsigned multiplying element. The element is reused over several clock cycles. In each cycle one byte of the first operand is multiplied by one byte of the second, and the 16-bit partial product is added into a 32-bit accumulator at its byte weight. Carries flow up into the higher bytes.

A mode input chooses how the operands are read. In unsigned mode the four partial products are the whole result. In two's complement mode, two further cycles apply corrections. If the second operand is negative, the first operand shifted up by 16 bits is subtracted. If the first operand is negative, the second operand shifted up by 16 bits is subtracted. These subtractions are taken modulo 2^32.

A client raises `start` for one cycle while the block is idle, with the operands and the mode presented at that time. It then waits for the one-cycle `done` pulse. The product stays on `product` until the next accepted start.

Top module: `seq_mul16`

## Requirements
- R1: A synchronous active-high `rst` sets `product` to 0 and drives `busy` and `done` low on the next clock. This also holds when `rst` arrives in the middle of an operation.
- R2: `start` is accepted only on a clock edge where `busy` is low. After an accepted start, `busy` is high from the following cycle.
- R3: With `signed_mode`=0, the final `product` equals op_a*op_b, with both operands read as unsigned.
- R4: With `signed_mode`=1, the final `product` equals op_a*op_b, with both operands read as two's complement, taken modulo 2^32. For example, 0x7FFF*0x8000 gives 0xC0008000.
- R5: `done` is high in the cycle after the 4th clock edge following the accepting edge in unsigned mode, and after the 6th such edge in signed mode.
- R6: `done` is high for exactly one cycle. `busy` is low whenever `done` is high.
- R7: After `done`, `product` holds its value until the next accepted start.
- R8: `op_a`, `op_b` and `signed_mode` are captured at the accepting edge. Changing them while `busy` is high has no effect on the result.
- R9: A `start` pulse while `busy` is high is ignored. The running operation keeps its result and its `done` timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply; sampled only while idle |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: product is final |
| product | output | 32 | 32-bit result |

## Verification
A wrong step or a wrong partial-product byte selection shows as a wrong `product` value at the `done` pulse. This appears within six cycles of the accepting start. A misplaced byte shift corrupts a whole byte lane rather than a single bit, so operands with bytes of 0xFF and 0x80 expose it. A sequencer that skips or repeats a correction step moves `done` off its 4- or 6-cycle slot. It also breaks the signed results only when an operand is negative, which is why the corner operands are run in both modes. A state that leaks across operations shows up either as an ignored start that changes the result, or as a `product` that drifts after `done`.

// File: rtl/seq_mul_pkg.sv
`timescale 1ns/1ps
package seq_mul_pkg;
  // Steps of one operation: four byte products, then two sign corrections
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LL   = 3'd1,  // lo(a) * lo(b), weight 0
    ST_LH   = 3'd2,  // lo(a) * hi(b), weight 1 byte
    ST_HL   = 3'd3,  // hi(a) * lo(b), weight 1 byte
    ST_HH   = 3'd4,  // hi(a) * hi(b), weight 2 bytes
    ST_CB   = 3'd5,  // subtract a<<16 when b is negative
    ST_CA   = 3'd6   // subtract b<<16 when a is negative
  } mul_st_e;
endpackage

// File: rtl/mul8_unsigned.sv
`timescale 1ns/1ps
module mul8_unsigned #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0]   x,
  input  logic [BYTE_W-1:0]   y,
  output logic [2*BYTE_W-1:0] p
);
  always_comb p = {{BYTE_W{1'b0}}, x} * {{BYTE_W{1'b0}}, y};
endmodule

// File: rtl/mul_seq_ctrl.sv
`timescale 1ns/1ps
module mul_seq_ctrl
  import seq_mul_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    mode_q,
  output mul_st_e st,
  output logic    load,
  output logic    finish,
  output logic    busy,
  output logic    done
);
  mul_st_e st_nx;

  assign load   = start && (st == ST_IDLE);
  assign finish = ((st == ST_HH) && !mode_q) || (st == ST_CA);
  assign busy   = (st != ST_IDLE);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_LL;
      ST_LL:   st_nx = ST_LH;
      ST_LH:   st_nx = ST_HL;
      ST_HL:   st_nx = ST_HH;
      ST_HH:   st_nx = mode_q ? ST_CB : ST_IDLE;
      ST_CB:   st_nx = ST_CA;
      ST_CA:   st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= finish;
    end
  end
endmodule

// File: rtl/mul_accum.sv
`timescale 1ns/1ps
module mul_accum
  import seq_mul_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int OP_W  = 2 * BYTE_W,
  localparam int RES_W = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  mul_st_e          st,
  input  logic             mode_in,
  input  logic [OP_W-1:0]  a_in,
  input  logic [OP_W-1:0]  b_in,
  output logic             mode_q,
  output logic             pp_fire,
  output logic             corr_fire,
  output logic [RES_W-1:0] acc
);
  logic [OP_W-1:0]   a_q, b_q;
  logic [BYTE_W-1:0] mx, my;
  logic [OP_W-1:0]   prod;
  logic [RES_W-1:0]  acc_nx;

  // Partial product placed at a given byte weight
  function automatic logic [RES_W-1:0] place_pp(input logic [OP_W-1:0] pp,
                                                input int unsigned nbytes);
    logic [RES_W-1:0] wide;
    wide = {{OP_W{1'b0}}, pp};
    return wide << (nbytes * BYTE_W);
  endfunction

  // Correction term: whole operand moved to the upper half, or zero
  function automatic logic [RES_W-1:0] corr_term(input logic [OP_W-1:0] op,
                                                 input logic en);
    return en ? {op, {OP_W{1'b0}}} : {RES_W{1'b0}};
  endfunction

  // Byte selection for the shared multiplier
  assign mx = (st == ST_LL || st == ST_LH) ? a_q[BYTE_W-1:0] : a_q[OP_W-1:BYTE_W];
  assign my = (st == ST_LL || st == ST_HL) ? b_q[BYTE_W-1:0] : b_q[OP_W-1:BYTE_W];

  mul8_unsigned #(.BYTE_W(BYTE_W)) u_mul (.x(mx), .y(my), .p(prod));

  assign pp_fire   = (st == ST_LL) || (st == ST_LH) || (st == ST_HL) || (st == ST_HH);
  assign corr_fire = ((st == ST_CB) && b_q[OP_W-1]) || ((st == ST_CA) && a_q[OP_W-1]);

  always_comb begin
    acc_nx = acc;
    unique case (st)
      ST_LL:   acc_nx = acc + place_pp(prod, 0);
      ST_LH,
      ST_HL:   acc_nx = acc + place_pp(prod, 1);
      ST_HH:   acc_nx = acc + place_pp(prod, 2);
      ST_CB:   acc_nx = acc - corr_term(a_q, b_q[OP_W-1]);
      ST_CA:   acc_nx = acc - corr_term(b_q, a_q[OP_W-1]);
      default: acc_nx = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      acc    <= '0;
      a_q    <= a_in;
      b_q    <= b_in;
      mode_q <= mode_in;
    end else begin
      acc    <= acc_nx;
    end
  end
endmodule

// File: rtl/seq_mul16.sv
`timescale 1ns/1ps
module seq_mul16
  import seq_mul_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int OP_W  = 2 * BYTE_W,
  localparam int RES_W = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             signed_mode,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] product
);
  mul_st_e st;
  logic    load, finish, mode_q, pp_fire, corr_fire;

  mul_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode_q(mode_q),
    .st(st), .load(load), .finish(finish), .busy(busy), .done(done)
  );

  mul_accum #(.BYTE_W(BYTE_W)) u_acc (
    .clk(clk), .rst(rst), .load(load), .st(st), .mode_in(signed_mode),
    .a_in(op_a), .b_in(op_b), .mode_q(mode_q), .pp_fire(pp_fire),
    .corr_fire(corr_fire), .acc(product)
  );
endmodule

// File: rtl/seq_mul16_chk.sv
`timescale 1ns/1ps
module seq_mul16_chk #(
  parameter int OP_W  = 16,
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             signed_mode,
  input logic [OP_W-1:0]  op_a,
  input logic [OP_W-1:0]  op_b,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] product,
  input logic             pp_fire,
  input logic             corr_fire
);
  logic [OP_W-1:0] ra, rb;
  logic            rm;
  logic [3:0]      cyc;

  function automatic logic [RES_W-1:0] model(input logic [OP_W-1:0] a,
                                             input logic [OP_W-1:0] b,
                                             input logic m);
    logic [RES_W-1:0] xa, xb;
    xa = m ? {{(RES_W-OP_W){a[OP_W-1]}}, a} : {{(RES_W-OP_W){1'b0}}, a};
    xb = m ? {{(RES_W-OP_W){b[OP_W-1]}}, b} : {{(RES_W-OP_W){1'b0}}, b};
    return xa * xb;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ra <= '0; rb <= '0; rm <= 1'b0; cyc <= '0;
    end else if (start && !busy) begin
      ra <= op_a; rb <= op_b; rm <= signed_mode; cyc <= '0;
    end else if (busy) begin
      cyc <= cyc + 4'd1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (product == '0 && !busy && !done));
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R3
  result_value_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == model(ra, rb, rm)));
  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == (rm ? 4'd6 : 4'd4)));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));
  // R4
  corr_mode_chk: assert property (@(posedge clk) disable iff (rst)
    corr_fire |-> (rm && busy && !pp_fire));
endmodule

bind seq_mul16 seq_mul16_chk #(.OP_W(OP_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
  .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product),
  .pp_fire(pp_fire), .corr_fire(corr_fire)
);

// File: tb/sim_seq_mul16.sv
`timescale 1ns/1ps
module sim_seq_mul16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [31:0] product;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  seq_mul16 u0 (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product)
  );

  // {mode, a, b, expected}
  localparam int NV = 14;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 16'h0000, 16'h0000, 32'h0000_0000},
    {1'b0, 16'h0001, 16'hFFFF, 32'h0000_FFFF},
    {1'b0, 16'hFFFF, 16'hFFFF, 32'hFFFE_0001},
    {1'b0, 16'h7FFF, 16'h8000, 32'h3FFF_8000},
    {1'b0, 16'h8000, 16'h8000, 32'h4000_0000},
    {1'b0, 16'hFFFF, 16'h7FFF, 32'h7FFE_8001},
    {1'b0, 16'h8000, 16'h0001, 32'h0000_8000},
    {1'b1, 16'hFFFF, 16'hFFFF, 32'h0000_0001},
    {1'b1, 16'h8000, 16'h8000, 32'h4000_0000},
    {1'b1, 16'h7FFF, 16'h8000, 32'hC000_8000},
    {1'b1, 16'h8000, 16'h0001, 32'hFFFF_8000},
    {1'b1, 16'hFFFF, 16'h7FFF, 32'hFFFF_8001},
    {1'b1, 16'h7FFF, 16'h7FFF, 32'h3FFF_0001},
    {1'b1, 16'h0000, 16'h8000, 32'h0000_0000}
  };

  function automatic logic [31:0] ref_mul(input logic m, input logic [15:0] a,
                                          input logic [15:0] b);
    longint p;
    if (m) p = longint'($signed(a)) * longint'($signed(b));
    else   p = longint'({16'h0, a}) * longint'({16'h0, b});
    return p[31:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Run one multiply; optionally disturb inputs and pulse start while busy
  task automatic run(input logic m, input logic [15:0] a, input logic [15:0] b,
                     input bit disturb, output logic [31:0] res, output int lat);
    @(negedge clk);
    start = 1'b1; signed_mode = m; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0; lat = 0;
    if (disturb) begin
      start = 1'b1; signed_mode = ~m; op_a = ~a; op_b = b ^ 16'h5A5A;
    end
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      start = 1'b0;
    end
    res = product;
  endtask

  task automatic full(input logic m, input logic [15:0] a, input logic [15:0] b,
                      input logic [31:0] exp, input bit disturb, input string tag);
    logic [31:0] res;
    int lat;
    run(m, a, b, disturb, res, lat);
    check(res == exp, tag, res, exp);
    check(lat == (m ? 6 : 4), "R5 latency", lat, m ? 6 : 4);
    check(!busy, "R6 busy low with done", {31'b0, busy}, 0);
    @(negedge clk);
    check(!done, "R6 done one cycle", {31'b0, done}, 0);
    repeat (2) @(negedge clk);
    check(product == res, "R7 product holds", product, res);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check(product == 0 && !busy && !done, "R1 reset state", product, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy, "R2 idle without start", {31'b0, busy}, 0);

    for (int i = 0; i < NV; i++) begin
      full(VEC[i][64], VEC[i][63:48], VEC[i][47:32], VEC[i][31:0], 1'b0,
           VEC[i][64] ? "R4 signed vector" : "R3 unsigned vector");
    end

    for (int i = 0; i < 24; i++) begin
      logic [15:0] a, b;
      logic m;
      a = 16'($urandom); b = 16'($urandom); m = i[0];
      full(m, a, b, ref_mul(m, a, b), 1'b0, m ? "R4 random signed" : "R3 random unsigned");
    end

    // R8 and R9: inputs changed and start pulsed while busy
    full(1'b0, 16'h1234, 16'hABCD, ref_mul(1'b0, 16'h1234, 16'hABCD), 1'b1, "R8 R9 unsigned ignored");
    full(1'b1, 16'h8001, 16'hFF7F, ref_mul(1'b1, 16'h8001, 16'hFF7F), 1'b1, "R8 R9 signed ignored");

    // R2: busy follows an accepted start
    @(negedge clk);
    start = 1'b1; signed_mode = 1'b1; op_a = 16'h9000; op_b = 16'h0003;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R2 busy after start", {31'b0, busy}, 1);

    // R1: reset in the middle of an operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(product == 0 && !busy && !done, "R1 mid-op reset", product, 0);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    check(!done && product == 0, "R1 no stale done", product, 0);

    full(1'b1, 16'h9000, 16'h0003, 32'hFFFE_B000, 1'b0, "R4 after reset");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule